// File: doc/BRIEF.md
# Gated Monotonic Wall Clock Register

The block holds a wall-clock register that a scheduler tries to move forward to a requested time. Each request carries a target value, a force flag and a one-cycle strobe. For each stream the block also receives the absolute wall-clock position that the stream's current period has reached, along with a mask that says which streams take part. Stream period tracking lives outside the block.

A normal request advances the register only when every participating stream has caught up with the target. A request that would move time backwards is dropped and latches an error. A forced request loads the target unconditionally. Repeated normal writes of the value already held are counted, and a warning is raised once they pile up. One cycle after each strobe the block reports whether the register now matches the target.

Top module: `wclk_gated_reg`

## Requirements
- R1: A strobe with force low and a target at or above the current value loads the target only if every stream with its mask bit set has a period position at or beyond the target. Otherwise the register keeps its value.
- R2: A stream whose bit in `strm_active_i` is low (bit i belongs to stream i) does not take part in the R1 check, whatever its position.
- R3: A strobe with force high loads the target whatever the stream positions are, and leaves the stale count unchanged.
- R4: A strobe with force low and a target below the current value leaves the register unchanged. It sets `back_err_o`, which stays high until reset.
- R5: A non-forced update whose target equals the current value is stale and raises the stale count by one, saturating at its maximum.
- R6: A non-forced update whose target is above the current value clears the stale count to zero.
- R7: `stale_warn_o` is high while the stale count is above 3, that is from the fourth consecutive stale update onward.
- R8: `done_o` is high for exactly the cycle after each strobe. From that cycle until the next report, `accepted_o` shows whether the register equals the strobe's target.
- R9: After reset `wclk_o` is 0 and `done_o`, `accepted_o`, `stale_warn_o` and `back_err_o` are all low.
- R10: `wclk_o` is the full register in one cycle and changes only at the clock edge that ends a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle request strobe |
| req_force_i | input | 1 | Load the target without the stream check |
| req_time_i | input | TW (64) | Requested wall-clock value |
| strm_active_i | input | NUM_STREAMS (3) | Per-stream participation mask |
| strm_pos_i | input | NUM_STREAMS*TW (192) | Stream period positions, stream i in bits [i*TW +: TW] |
| wclk_o | output | TW (64) | Current wall-clock value |
| done_o | output | 1 | Report pulse, one cycle after a strobe |
| accepted_o | output | 1 | Register equalled the target after the last strobe |
| stale_warn_o | output | 1 | Stale count above 3 |
| back_err_o | output | 1 | Sticky backward-request error |

## Verification
A wrong gate decision shows up on `wclk_o` and `accepted_o` in the cycle after the strobe, so every scenario samples both there. A stale count that is off stays hidden until the warning should toggle. For that reason the bench walks it through exactly four stale writes, a forced write and a clearing write, and checks the warning after each one. A lost sticky error appears only after a later good update, so the error flag is checked again after a legal advance.

// File: rtl/wclk_pkg.sv
package wclk_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_FORCE,
    ACT_ADV,
    ACT_STALE,
    ACT_BACK,
    ACT_HOLD
  } wclk_act_e;
endpackage

// File: rtl/wclk_gate.sv
module wclk_gate #(
  parameter int NUM_STREAMS = 3,
  parameter int TW          = 64,
  localparam int POS_W      = NUM_STREAMS * TW
) (
  input  logic [NUM_STREAMS-1:0] active_i,
  input  logic [POS_W-1:0]       pos_i,
  input  logic [TW-1:0]          req_i,
  output logic                   all_ok_o
);
  logic [NUM_STREAMS-1:0] ok;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_strm
    assign ok[g] = !active_i[g] || (pos_i[g*TW +: TW] >= req_i);
  end

  assign all_ok_o = &ok;
endmodule

// File: rtl/wclk_decide.sv
module wclk_decide
  import wclk_pkg::*;
#(
  parameter int TW = 64
) (
  input  logic          valid_i,
  input  logic          force_i,
  input  logic          gate_ok_i,
  input  logic [TW-1:0] req_i,
  input  logic [TW-1:0] cur_i,
  output wclk_act_e     act_o
);
  always_comb begin
    act_o = ACT_NONE;
    if (valid_i) begin
      if (force_i)           act_o = ACT_FORCE;
      else if (req_i < cur_i) act_o = ACT_BACK;
      else if (!gate_ok_i)   act_o = ACT_HOLD;
      else if (req_i == cur_i) act_o = ACT_STALE;
      else                   act_o = ACT_ADV;
    end
  end
endmodule

// File: rtl/wclk_stale.sv
module wclk_stale
  import wclk_pkg::*;
#(
  parameter int STALE_W     = 3,
  parameter int STALE_LIMIT = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  wclk_act_e act_i,
  output logic      warn_o
);
  localparam logic [STALE_W-1:0] LIM     = STALE_W'(STALE_LIMIT);
  localparam logic [STALE_W-1:0] CNT_MAX = '1;

  logic [STALE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (act_i == ACT_ADV) begin
      cnt_q <= '0;
    end else if (act_i == ACT_STALE && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign warn_o = cnt_q > LIM;

  AST_STALE_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_STALE && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R5
  AST_STALE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_ADV) |=> !warn_o); // R6
  AST_FORCE_KEEPS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_FORCE) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/wclk_gated_reg.sv
module wclk_gated_reg
  import wclk_pkg::*;
#(
  parameter int NUM_STREAMS = 3,
  parameter int TW          = 64,
  parameter int STALE_W     = 3,
  parameter int STALE_LIMIT = 3,
  localparam int POS_W      = NUM_STREAMS * TW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic                   req_force_i,
  input  logic [TW-1:0]          req_time_i,
  input  logic [NUM_STREAMS-1:0] strm_active_i,
  input  logic [POS_W-1:0]       strm_pos_i,
  output logic [TW-1:0]          wclk_o,
  output logic                   done_o,
  output logic                   accepted_o,
  output logic                   stale_warn_o,
  output logic                   back_err_o
);
  logic [TW-1:0] wclk_q, wclk_d;
  logic          done_q, acc_q, err_q;
  logic          gate_ok;
  wclk_act_e     act;

  wclk_gate #(.NUM_STREAMS(NUM_STREAMS), .TW(TW)) u_gate (
    .active_i (strm_active_i),
    .pos_i    (strm_pos_i),
    .req_i    (req_time_i),
    .all_ok_o (gate_ok)
  );

  wclk_decide #(.TW(TW)) u_decide (
    .valid_i   (req_valid_i),
    .force_i   (req_force_i),
    .gate_ok_i (gate_ok),
    .req_i     (req_time_i),
    .cur_i     (wclk_q),
    .act_o     (act)
  );

  wclk_stale #(.STALE_W(STALE_W), .STALE_LIMIT(STALE_LIMIT)) u_stale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .warn_o (stale_warn_o)
  );

  always_comb begin
    wclk_d = wclk_q;
    if (act == ACT_FORCE || act == ACT_ADV) wclk_d = req_time_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wclk_q <= '0;
      done_q <= 1'b0;
      acc_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      wclk_q <= wclk_d;
      done_q <= req_valid_i;
      if (req_valid_i) acc_q <= (wclk_d == req_time_i);
      if (act == ACT_BACK) err_q <= 1'b1;
    end
  end

  assign wclk_o     = wclk_q;
  assign done_o     = done_q;
  assign accepted_o = acc_q;
  assign back_err_o = err_q;

  AST_FORCE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_force_i) |=> wclk_o == $past(req_time_i)); // R3
  AST_NO_BACKWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_force_i) |=> wclk_o >= $past(wclk_o)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    back_err_o |=> back_err_o); // R4
  AST_BLOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_force_i && !gate_ok) |=> $stable(wclk_o)); // R1
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(wclk_o)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> done_o); // R8
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !done_o); // R8
endmodule

// File: tb/wclk_gated_reg_tb_top.sv
module wclk_gated_reg_tb_top;
  localparam int NS = 3;
  localparam int TW = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_force = 1'b0;
  logic [TW-1:0]   req_time = '0;
  logic [NS-1:0]   active = '1;
  logic [NS*TW-1:0] pos = '0;
  logic [TW-1:0]   wclk;
  logic            done, acc, warn, err;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wclk_gated_reg dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .req_valid_i   (req_valid),
    .req_force_i   (req_force),
    .req_time_i    (req_time),
    .strm_active_i (active),
    .strm_pos_i    (pos),
    .wclk_o        (wclk),
    .done_o        (done),
    .accepted_o    (acc),
    .stale_warn_o  (warn),
    .back_err_o    (err)
  );

  task automatic chk(input string tag, input logic [TW-1:0] a, input logic [TW-1:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  task automatic set_pos(input logic [TW-1:0] p0, input logic [TW-1:0] p1, input logic [TW-1:0] p2);
    pos = {p2, p1, p0};
  endtask

  // drive at negedge, sample at the following negedge
  task automatic strobe(input logic [TW-1:0] t, input logic f);
    req_time  = t;
    req_force = f;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_force = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 wclk", wclk, 0);
    chk("R9 done", TW'(done), 0);
    chk("R9 accepted", TW'(acc), 0);
    chk("R9 warn", TW'(warn), 0);
    chk("R9 err", TW'(err), 0);
  endtask

  task automatic t_gate_pass;
    active = 3'b111;
    set_pos(1000, 1000, 1000);
    strobe(100, 1'b0);
    chk("R1 advance", wclk, 100);
    chk("R8 done", TW'(done), 1);
    chk("R8 accepted", TW'(acc), 1);
    @(negedge clk);
    chk("R8 done drops", TW'(done), 0);
    chk("R10 idle stable", wclk, 100);
  endtask

  task automatic t_gate_block;
    set_pos(1000, 150, 1000);
    strobe(200, 1'b0);
    chk("R1 held", wclk, 100);
    chk("R8 not accepted", TW'(acc), 0);
  endtask

  task automatic t_mask;
    active = 3'b101;
    strobe(200, 1'b0);
    chk("R2 masked stream ignored", wclk, 200);
    chk("R2 accepted", TW'(acc), 1);
    active = 3'b111;
  endtask

  task automatic t_force;
    set_pos(0, 0, 0);
    strobe(500, 1'b1);
    chk("R3 forced load", wclk, 500);
    chk("R3 accepted", TW'(acc), 1);
  endtask

  task automatic t_backward;
    set_pos(1000, 1000, 1000);
    strobe(300, 1'b0);
    chk("R4 no backward", wclk, 500);
    chk("R4 err set", TW'(err), 1);
    chk("R4 not accepted", TW'(acc), 0);
    strobe(600, 1'b0);
    chk("R6 advance after error", wclk, 600);
    chk("R4 err sticky", TW'(err), 1);
  endtask

  task automatic t_stale;
    for (int i = 1; i <= 4; i++) begin
      strobe(600, 1'b0);
      chk("R5 stale keeps value", wclk, 600);
      chk("R7 warn level", TW'(warn), (i > 3) ? 1 : 0);
    end
    strobe(600, 1'b1);
    chk("R3 force keeps stale count", TW'(warn), 1);
    strobe(700, 1'b0);
    chk("R6 advance", wclk, 700);
    chk("R6 stale cleared", TW'(warn), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_gate_pass();
    t_gate_block();
    t_mask();
    t_force();
    t_backward();
    t_stale();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule